// File: doc/BRIEF.md
# Accumulator Fetch-Execute Core

This block is a minimal accumulator processor. It has one synchronous memory port, which holds both the program and its data. The core keeps three registers: a program counter, an instruction register and an accumulator. It steps through a fixed state sequence. First it reads the instruction word at the program counter and advances the counter. It then captures the returned word in the instruction register. Finally it performs the memory reference that the opcode names.

Three operations are defined: load the accumulator from memory, store the accumulator to memory, and add a memory word to the accumulator. Any other opcode stops the core. The core stays stopped, with its halt output raised, until reset. The memory returns read data one clock after the address is presented, and it writes on the clock edge where write enable is high.

Top module: `acc_core`

## Requirements
- R1: While reset is low and immediately after it, the program counter, accumulator and halt flag are zero, so the first fetch reads address 0 and write enable is low.
- R2: An instruction word carries its opcode in bits 15:12 and its operand address in bits 11:0; every 12-bit address, including 0xFFF, is reachable.
- R3: The program counter advances by one after every fetch, so instructions execute from consecutive addresses.
- R4: Opcode 4'b0001 replaces the accumulator with the word at the operand address.
- R5: Opcode 4'b0010 writes the accumulator to the operand address in exactly one cycle with write enable high; no other opcode writes memory.
- R6: Opcode 4'b0101 adds the word at the operand address to the accumulator as 16-bit two's complement, discarding the carry.
- R7: Load and add take 4 cycles each (fetch, decode, operand read, execute), store takes 3 cycles, and an undefined opcode raises halt 3 cycles after its fetch starts.
- R8: Any opcode other than 0001, 0010 and 0101 sets a halt flag that holds until reset; while halted the core issues no write and the memory address stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 12 | Memory address (program counter or operand address) |
| mem_wdata_o | output | 16 | Write data, always the accumulator |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the address |
| halt_o | output | 1 | Sticky halt after an undefined opcode |

## Verification
The in-line assertions check several properties on every cycle. Halt stays set once raised, and no write occurs while halted. Each write lasts a single cycle and is followed by a fetch. Every fetch moves the address seen on the port up by one. The accumulator holds its value in cycles that neither load nor add. Only the bench's programs can show that loaded, summed and stored values are right, including a sum that wraps through 0x8000 and 0x0000. The same holds for the exact cycle count of each instruction class, which the bench measures as the time until halt, and for the rule that a reset clears the accumulator between programs.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'b0010;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'b0101;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_OPER,
    ST_EXEC,
    ST_HALT
  } state_e;

  typedef struct packed {
    logic pc_inc;    // fetch cycle: address from pc, pc advances
    logic ir_we;     // capture returned instruction word
    logic opnd_sel;  // drive operand address instead of pc
    logic mem_we;    // store write cycle
    logic acc_load;  // accumulator <= read data
    logic acc_add;   // accumulator <= accumulator + read data
  } ctrl_t;
endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  output ctrl_t            ctrl_o,
  output logic             halt_o
);

  state_e state_q, state_d;
  logic   is_load, is_store, is_add;

  assign is_load  = (opcode_i == OPC_LOAD);
  assign is_store = (opcode_i == OPC_STORE);
  assign is_add   = (opcode_i == OPC_ADD);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = ST_OPER;
      ST_OPER: begin
        if (is_load || is_add) state_d = ST_EXEC;
        else if (is_store)     state_d = ST_FETCH;
        else                   state_d = ST_HALT;
      end
      ST_EXEC:   state_d = ST_FETCH;
      ST_HALT:   state_d = ST_HALT;
      default:   state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  always_comb begin
    ctrl_o          = '0;
    ctrl_o.pc_inc   = (state_q == ST_FETCH);
    ctrl_o.ir_we    = (state_q == ST_DECODE);
    ctrl_o.opnd_sel = (state_q == ST_OPER);
    ctrl_o.mem_we   = (state_q == ST_OPER) && is_store;
    ctrl_o.acc_load = (state_q == ST_EXEC) && is_load;
    ctrl_o.acc_add  = (state_q == ST_EXEC) && is_add;
  end

  assign halt_o = (state_q == ST_HALT);

  // R8
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);

  // R8
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !ctrl_o.mem_we && !ctrl_o.pc_inc);

  // R5
  single_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o.mem_we |=> !ctrl_o.mem_we);

  // R7
  store_refetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o.mem_we |=> ctrl_o.pc_inc);

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter  int DATA_W = 16,
  localparam int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [OPC_W-1:0]  opcode_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);

  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] acc_q, acc_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pc_q <= '0;
    else if (ctrl_i.pc_inc) pc_q <= pc_q + ADDR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ir_q <= '0;
    else if (ctrl_i.ir_we) ir_q <= mem_rdata_i;
  end

  // carry out of the top bit is dropped
  always_comb begin
    acc_d = acc_q;
    if (ctrl_i.acc_load)     acc_d = mem_rdata_i;
    else if (ctrl_i.acc_add) acc_d = acc_q + mem_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign opcode_o    = ir_q[DATA_W-1 -: OPC_W];
  assign mem_addr_o  = ctrl_i.opnd_sel ? ir_q[ADDR_W-1:0] : pc_q;
  assign mem_wdata_o = acc_q;

  // R3
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.pc_inc |=> mem_addr_o == $past(mem_addr_o) + ADDR_W'(1));

  // R6
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_i.acc_load || ctrl_i.acc_add) |=> $stable(acc_q));

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter  int DATA_W = 16,
  localparam int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              halt_o
);

  ctrl_t            ctrl;
  logic [OPC_W-1:0] opcode;

  acc_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (opcode),
    .ctrl_o   (ctrl),
    .halt_o   (halt_o)
  );

  acc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_i      (ctrl),
    .mem_rdata_i (mem_rdata_i),
    .opcode_o    (opcode),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  assign mem_we_o = ctrl.mem_we;

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !mem_we_o && !halt_o);

endmodule

// File: tb/acc_core_tb_top.sv
`timescale 1ns/1ps
module acc_core_tb_top;
  localparam int DW = 16;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          mem_we;
  logic          halt;

  acc_core #(.DATA_W(DW)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_we_o    (mem_we),
    .mem_rdata_i (mem_rdata),
    .halt_o      (halt)
  );

  // bench memory with a preload port
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;

  always @(posedge clk) begin
    if (ld_en)       mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } exp_t;
  exp_t exp_q[$];

  logic [DW-1:0] shadow [0:(1<<AW)-1];
  logic [DW-1:0] m_acc;
  logic [AW-1:0] p_pc;
  bit            m_halted;
  int            exp_cyc;
  int            n_chk = 0;
  int            n_err = 0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic poke(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    shadow[a] = d;
  endtask

  task automatic poke_done();
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic new_prog();
    m_acc = '0; p_pc = '0; m_halted = 1'b0; exp_cyc = 0;
    exp_q.delete();
  endtask

  // driver: places one instruction and pushes the expected outcome
  task automatic emit(logic [3:0] op, logic [AW-1:0] a);
    exp_t e;
    poke(p_pc, {op, a});
    p_pc++;
    if (!m_halted) begin
      case (op)
        4'b0001: begin m_acc = shadow[a]; exp_cyc += 4; end
        4'b0101: begin m_acc = m_acc + shadow[a]; exp_cyc += 4; end
        4'b0010: begin
          shadow[a] = m_acc; e.a = a; e.d = m_acc;
          exp_q.push_back(e); exp_cyc += 3;
        end
        default: begin m_halted = 1'b1; exp_cyc += 3; end
      endcase
    end
  endtask

  // monitor: pops expected stores as writes appear
  exp_t got;
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected write", {20'h0, mem_addr}, 32'h0);
      end else begin
        got = exp_q.pop_front();
        check(mem_addr == got.a, "R5 R2 store address", {20'h0, mem_addr}, {20'h0, got.a});
        check(mem_wdata == got.d, "R5 store data (R4 R6)", {16'h0, mem_wdata}, {16'h0, got.d});
      end
    end
  end

  task automatic run_prog();
    int n;
    logic [AW-1:0] hold_a;
    @(negedge clk);
    // R1
    check(mem_addr == '0 && !mem_we && !halt, "R1 reset state", {19'h0, halt, mem_addr}, 32'h0);
    rst_n = 1'b1;
    n = 0;
    while (!halt && n < 2000) begin
      @(negedge clk);
      n++;
    end
    // R7 R3
    check(n == exp_cyc, "R7 cycles until halt", n, exp_cyc);
    check(exp_q.size() == 0, "R5 all expected stores seen", exp_q.size(), 0);
    hold_a = mem_addr;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      // R8
      check(halt && !mem_we && mem_addr == hold_a, "R8 halted and quiet",
            {18'h0, halt, mem_we, mem_addr}, {19'h1, 1'b0, hold_a});
    end
    @(negedge clk);
    rst_n = 1'b0;
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    // program 1: load, add, wrap, top address
    new_prog();
    poke(12'h100, 16'h1234); poke(12'h101, 16'h0111); poke(12'h102, 16'hFFFF);
    poke(12'h103, 16'h7FFF); poke(12'h104, 16'h0001); poke(12'h105, 16'h8000);
    poke(12'hFFF, 16'hAAAA);
    emit(4'b0001, 12'h100);
    emit(4'b0101, 12'h101);
    emit(4'b0010, 12'h200);  // 0x1345
    emit(4'b0101, 12'h102);
    emit(4'b0010, 12'h201);  // 0x1344
    emit(4'b0001, 12'h103);
    emit(4'b0101, 12'h104);
    emit(4'b0010, 12'h202);  // 0x8000
    emit(4'b0101, 12'h105);
    emit(4'b0010, 12'hFFF);  // 0x0000
    emit(4'b0000, 12'h000);
    poke_done();
    run_prog();
    // R6
    check(mem[12'h202] == 16'h8000, "R6 positive overflow wraps", {16'h0, mem[12'h202]}, 32'h8000);
    check(mem[12'hFFF] == 16'h0000, "R6 R2 wrap to zero at top address", {16'h0, mem[12'hFFF]}, 32'h0);
    // R4
    check(mem[12'h201] == 16'h1344, "R4 load then adds", {16'h0, mem[12'h201]}, 32'h1344);

    // program 2: store right after reset, then stop on 0011
    new_prog();
    poke(12'h300, 16'h5555); poke(12'h301, 16'hABCD); poke(12'h303, 16'h5555);
    emit(4'b0010, 12'h300);  // accumulator cleared by reset
    emit(4'b0001, 12'h301);
    emit(4'b0010, 12'h302);
    emit(4'b0011, 12'h301);
    emit(4'b0010, 12'h303);  // never reached
    poke_done();
    run_prog();
    // R1
    check(mem[12'h300] == 16'h0000, "R1 accumulator cleared by reset", {16'h0, mem[12'h300]}, 32'h0);
    // R8
    check(mem[12'h303] == 16'h5555, "R8 store after halt not executed", {16'h0, mem[12'h303]}, 32'h5555);
    // R4
    check(mem[12'h302] == 16'hABCD, "R4 load to store", {16'h0, mem[12'h302]}, 32'hABCD);

    // program 3: undefined 1110 as the first instruction
    new_prog();
    emit(4'b1110, 12'h010);
    emit(4'b0010, 12'h310);
    poke_done();
    run_prog();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule